// File: doc/BRIEF.md
# Parallel Port Mode Controller

This block holds the operating state of a host-side parallel port: a 3-bit mode field and a transfer-direction bit. Software writes both through a small register bus. The block decides which mode changes are legal and tells the data path which features to turn on: the FIFO, and the automatic control-line handshake. It does not take part in the peripheral negotiation, drive the cable or move data.

Mode changes follow a hub-and-spoke rule. The two basic modes (000 standard, 001 byte-wide bidirectional) are the hub. From the hub, any mode can be entered. From any other mode, the port may only return to one of the two basic modes. Direction may change only in mode 001.

The data path reports whether its FIFO is empty. The block turns this into an exit-safe indication for software. If software leaves a transfer mode while data is still queued, the block records this in a sticky flag. A write that the rule refuses raises a one-cycle reject pulse.

Top module: `ppm_ctrl`

## Requirements
- R1: After a synchronous active-low reset, mode is 000, direction is 0, and fifo_en, hs_en, mode_reject and data_left are all 0.
- R2: While the mode is 000 or 001, a write to address 0 moves the mode to the value in bits [7:5] of the write data, whatever that value is. The new mode is visible the cycle after the write.
- R3: While the mode is neither 000 nor 001, a mode write takes effect only if it requests 000 or 001. Any other requested value leaves the mode unchanged. A write requesting the current mode is a no-op and is not a rejection.
- R4: mode_reject is high for exactly the one cycle after a mode write that R3 refuses, and is low otherwise.
- R5: A write to address 1 loads the direction from bit 5 of the write data only while the mode is 001. In every other mode, the write leaves the direction unchanged.
- R6: hs_en is high exactly when the mode is 010 or 011 (011 being the extended-capability transfer mode).
- R7: fifo_en is high exactly when the mode is 010 (FIFO mode) or 011; it is therefore low out of reset.
- R8: data_left is set when a write moves the mode out of 010 or 011 while fifo_empty is low. It then stays set until a write to address 0 has bit 0 set. If the same write both sets and clears the flag, setting wins.
- R9: exit_safe is high when fifo_empty is high or the mode is neither 010 nor 011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 1 | Register select: 0 mode/clear, 1 direction |
| host_wdata | input | 8 | Write data |
| fifo_empty | input | 1 | FIFO empty indication from the data path |
| mode | output | 3 | Current operating mode |
| dir | output | 1 | Transfer direction, 0 = forward with drivers on |
| fifo_en | output | 1 | FIFO enabled for the current mode |
| hs_en | output | 1 | Hardware handshake enabled |
| exit_safe | output | 1 | Leaving the current mode would not strand data |
| mode_reject | output | 1 | One-cycle pulse after a refused mode write |
| data_left | output | 1 | Sticky: a transfer mode was left with data pending |

## Verification
The bench walks the port through the hub and out along several spokes. It tries spoke-to-spoke jumps, which a design with a too-loose rule would accept, changing the mode and missing the reject pulse. It rewrites the current non-basic mode, where a strict design would raise a false reject. Direction writes are issued in modes 000 and 011, where a careless design would flip the bit. Exits from transfer modes are made with the FIFO both full and empty, and the clear bit is checked. A design with the wrong priority or no stickiness would show data_left wrong at the next sample.

// File: rtl/ppm_pkg.sv
// Package: shared constants and helpers for the parallel port mode controller.
// Assumes a 3-bit mode field; modes 000/001 are basic, 010/011 are transfer modes.
package ppm_pkg;
    localparam int MODE_W      = 3;
    localparam int MODE_LSB    = 5;   // mode field position in a mode write
    localparam int DIR_BIT     = 5;   // direction bit in a direction write
    localparam int CLR_BIT     = 0;   // sticky-flag clear bit in a mode write
    localparam logic [MODE_W-1:0] MODE_STD  = 3'b000;
    localparam logic [MODE_W-1:0] MODE_BYTE = 3'b001;
    localparam logic [MODE_W-1:0] MODE_FIFO = 3'b010;
    localparam logic [MODE_W-1:0] MODE_ECP  = 3'b011;

    // True for the two hub modes.
    function automatic logic is_basic(input logic [MODE_W-1:0] m);
        return (m == MODE_STD) || (m == MODE_BYTE);
    endfunction

    // True for the modes that move data through the FIFO.
    function automatic logic is_xfer(input logic [MODE_W-1:0] m);
        return (m == MODE_FIFO) || (m == MODE_ECP);
    endfunction
endpackage

// File: rtl/ppm_bus_decode.sv
// Module: splits host writes into mode, clear and direction requests.
// Assumes single-cycle write strobes; address 0 = mode/clear, address 1 = direction.
module ppm_bus_decode
    import ppm_pkg::*;
#(
    parameter int ADDR_W = 1,
    parameter int DATA_W = 8
) (
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              mode_wr,
    output logic [MODE_W-1:0] mode_req,
    output logic              clr_req,
    output logic              dir_wr,
    output logic              dir_req
);
    localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] DIR_ADDR  = ADDR_W'(1);

    // Decode the strobe and extract the fields.
    always_comb begin
        mode_wr  = we && (addr == MODE_ADDR);
        mode_req = wdata[MODE_LSB +: MODE_W];
        clr_req  = mode_wr && wdata[CLR_BIT];
        dir_wr   = we && (addr == DIR_ADDR);
        dir_req  = wdata[DIR_BIT];
    end
endmodule

// File: rtl/ppm_mode_ctl.sv
// Module: mode register with hub-and-spoke legality check and reject pulse.
// Assumes mode_wr is one cycle per write; same-value writes are no-ops.
module ppm_mode_ctl
    import ppm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_req,
    output logic [MODE_W-1:0] mode_q,
    output logic              reject_q,
    output logic              leave_xfer
);
    logic change;
    logic legal;
    logic accept;

    // Classify the requested transition.
    always_comb begin
        change     = mode_wr && (mode_req != mode_q);
        legal      = is_basic(mode_q) || is_basic(mode_req);
        accept     = change && legal;
        leave_xfer = accept && is_xfer(mode_q);
    end

    // Hold the mode and register the reject pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MODE_STD;
            reject_q <= 1'b0;
        end else begin
            if (accept) mode_q <= mode_req;
            reject_q <= change && !legal;
        end
    end
endmodule

// File: rtl/ppm_dir_reg.sv
// Module: direction bit, writable only in the byte-wide bidirectional mode.
// Assumes reset direction is forward (drivers enabled).
module ppm_dir_reg
    import ppm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_wr,
    input  logic              dir_req,
    input  logic [MODE_W-1:0] mode_q,
    output logic              dir_q
);
    // Load direction only when the mode allows it.
    always_ff @(posedge clk) begin
        if (!rst_n)                             dir_q <= 1'b0;
        else if (dir_wr && mode_q == MODE_BYTE) dir_q <= dir_req;
    end
endmodule

// File: rtl/ppm_status.sv
// Module: feature enables, exit qualification and the sticky data-left flag.
// Assumes fifo_empty is synchronous to clk.
module ppm_status
    import ppm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_q,
    input  logic              leave_xfer,
    input  logic              clr_req,
    input  logic              fifo_empty,
    output logic              fifo_en,
    output logic              hs_en,
    output logic              exit_safe,
    output logic              left_q
);
    // Decode per-mode enables and the exit qualifier.
    always_comb begin
        fifo_en   = is_xfer(mode_q);
        hs_en     = is_xfer(mode_q);
        exit_safe = fifo_empty || !is_xfer(mode_q);
    end

    // Sticky flag: set on a dirty exit, clear on request, set wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                        left_q <= 1'b0;
        else if (leave_xfer && !fifo_empty) left_q <= 1'b1;
        else if (clr_req)                  left_q <= 1'b0;
    end
endmodule

// File: rtl/ppm_ctrl.sv
// Module: top of the parallel port mode controller.
// Assumes a single-cycle write bus and a FIFO empty flag from the data path.
module ppm_ctrl
    import ppm_pkg::*;
#(
    parameter int ADDR_W = 1,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              fifo_empty,
    output logic [MODE_W-1:0] mode,
    output logic              dir,
    output logic              fifo_en,
    output logic              hs_en,
    output logic              exit_safe,
    output logic              mode_reject,
    output logic              data_left
);
    logic              mode_wr, clr_req, dir_wr, dir_req, leave_xfer;
    logic [MODE_W-1:0] mode_req;

    ppm_bus_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .we(host_we), .addr(host_addr), .wdata(host_wdata),
        .mode_wr(mode_wr), .mode_req(mode_req), .clr_req(clr_req),
        .dir_wr(dir_wr), .dir_req(dir_req)
    );

    ppm_mode_ctl u_mode (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_req(mode_req),
        .mode_q(mode), .reject_q(mode_reject), .leave_xfer(leave_xfer)
    );

    ppm_dir_reg u_dir (
        .clk(clk), .rst_n(rst_n), .dir_wr(dir_wr), .dir_req(dir_req),
        .mode_q(mode), .dir_q(dir)
    );

    ppm_status u_stat (
        .clk(clk), .rst_n(rst_n), .mode_q(mode), .leave_xfer(leave_xfer),
        .clr_req(clr_req), .fifo_empty(fifo_empty), .fifo_en(fifo_en),
        .hs_en(hs_en), .exit_safe(exit_safe), .left_q(data_left)
    );
endmodule

// File: rtl/ppm_ctrl_chk.sv
// Checker: temporal properties of ppm_ctrl, bound to every instance.
module ppm_ctrl_chk
    import ppm_pkg::*;
#(
    parameter int ADDR_W = 1,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_we,
    input logic [ADDR_W-1:0] host_addr,
    input logic [DATA_W-1:0] host_wdata,
    input logic [MODE_W-1:0] mode,
    input logic              dir,
    input logic              hs_en,
    input logic              mode_reject,
    input logic              data_left
);
    AST_MODE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != $past(mode)) |-> ($past(host_we) && $past(host_addr) == '0)); // R2

    AST_SPOKE_TO_HUB: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_basic($past(mode)) && mode != $past(mode)) |-> is_basic(mode)); // R3

    AST_REJECT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_reject |-> ($past(host_we) && $past(host_addr) == '0 && $stable(mode))); // R4

    AST_DIR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (dir != $past(dir)) |-> ($past(mode) == MODE_BYTE)); // R5

    AST_HS_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en != $past(hs_en)) |-> $past(host_we)); // R6

    AST_LEFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(data_left) |-> ($past(host_we) && $past(host_addr) == '0
                              && $past(host_wdata[CLR_BIT]))); // R8
endmodule

bind ppm_ctrl ppm_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .mode(mode), .dir(dir), .hs_en(hs_en),
    .mode_reject(mode_reject), .data_left(data_left)
);

// File: tb/sim_ppm_ctrl.sv
module sim_ppm_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_we = 1'b0;
    logic [0:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic       fifo_empty = 1'b1;
    logic [2:0] mode;
    logic       dir, fifo_en, hs_en, exit_safe, mode_reject, data_left;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // Reference state
    logic [2:0] rm = 3'b000;
    logic       rd = 1'b0;
    logic       rp = 1'b0;

    logic [8:0] exp_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;   // 125 MHz

    ppm_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .fifo_empty(fifo_empty), .mode(mode), .dir(dir),
        .fifo_en(fifo_en), .hs_en(hs_en), .exit_safe(exit_safe),
        .mode_reject(mode_reject), .data_left(data_left)
    );

    function automatic logic basic_m(input logic [2:0] m);
        return m == 3'b000 || m == 3'b001;
    endfunction
    function automatic logic xfer_m(input logic [2:0] m);
        return m == 3'b010 || m == 3'b011;
    endfunction

    // Driver: one bus write, then push the expected outputs.
    task automatic wr(input logic a, input logic [7:0] dat, input logic fe, input string rq);
        logic rej;
        logic [2:0] req;
        rej = 1'b0;
        @(posedge clk); #2;
        host_we = 1'b1; host_addr = a; host_wdata = dat; fifo_empty = fe;
        if (a == 1'b0) begin
            req = dat[7:5];
            if (req != rm) begin
                if (basic_m(rm) || basic_m(req)) begin
                    if (dat[0]) rp = 1'b0;
                    if (xfer_m(rm) && !fe) rp = 1'b1;
                    rm = req;
                end else rej = 1'b1;
            end else if (dat[0]) rp = 1'b0;
        end else if (rm == 3'b001) rd = dat[5];
        @(posedge clk); #2;
        host_we = 1'b0;
        exp_q.push_back({rm, rd, xfer_m(rm), xfer_m(rm), rej, rp, fe || !xfer_m(rm)});
        tag_q.push_back(rq);
    endtask

    // Monitor: pop and compare at the falling edge after each write.
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                logic [8:0] e, a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {mode, dir, fifo_en, hs_en, mode_reject, data_left, exit_safe};
                tests++;
                if (a !== e) begin
                    fails++;
                    $display("FAIL %s: got %b expected %b (mode,dir,fe,hs,rej,left,safe)", t, a, e);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        tests++;
        if ({mode, dir, fifo_en, hs_en, mode_reject, data_left} !== 8'b0) begin
            fails++;
            $display("FAIL R1: got %b expected %b", {mode, dir, fifo_en, hs_en, mode_reject, data_left}, 8'b0);
        end
        wr(1'b1, 8'h20, 1'b1, "R5 dir write in 000 ignored");
        wr(1'b0, 8'h20, 1'b1, "R2 000->001");
        wr(1'b1, 8'h20, 1'b1, "R5 dir set in 001");
        wr(1'b0, 8'h60, 1'b1, "R2 R6 R7 001->011");
        wr(1'b1, 8'h00, 1'b1, "R5 dir write in 011 ignored");
        wr(1'b0, 8'h40, 1'b1, "R3 R4 011->010 refused");
        wr(1'b0, 8'h60, 1'b1, "R3 R4 same-mode write no reject");
        wr(1'b0, 8'h60, 1'b0, "R9 exit unsafe with data");
        wr(1'b0, 8'h00, 1'b0, "R8 dirty exit 011->000");
        wr(1'b0, 8'h00, 1'b0, "R8 flag sticky on plain write");
        wr(1'b0, 8'h01, 1'b1, "R8 clear bit");
        wr(1'b0, 8'h40, 1'b1, "R2 R7 000->010");
        wr(1'b0, 8'h21, 1'b0, "R8 set beats clear 010->001");
        wr(1'b0, 8'h41, 1'b1, "R8 clear and 001->010");
        wr(1'b0, 8'h20, 1'b1, "R8 clean exit 010->001");
        wr(1'b0, 8'hE0, 1'b1, "R2 R6 001->111");
        wr(1'b0, 8'hA0, 1'b1, "R3 R4 111->101 refused");
        wr(1'b0, 8'h60, 1'b0, "R3 R4 111->011 refused");
        wr(1'b0, 8'h20, 1'b1, "R3 111->001");
        wr(1'b1, 8'h00, 1'b1, "R5 dir cleared in 001");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule